// File: doc/BRIEF.md
# Byte-Serial Inverse Residue Encoder

This block sits on a byte stream and turns each word into an arithmetically checkable word. Data bytes of a word arrive one per cycle on a valid/ready input. A start-of-word flag marks the first byte and an end-of-word flag marks the last. Every data byte is forwarded to the output unchanged and in the same cycle. After the last data byte has been taken, the block appends one extra byte. That byte is the check modulus A = 2^N − 1 minus the running modulo-A residue of the word's data bytes.

The residue is kept with an end-around-carry adder: a carry out of the top bit is folded back into bit 0. Because of this, any byte-serial checker that adds all bytes of the encoded word modulo A sees zero, where an all-ones sum also counts as zero. The appended byte is flagged by end-of-word on the output side. The input is held off while it is pending, so output backpressure stalls the whole stream without loss.

Top module: `ir_encoder`

## Requirements
- R1: During reset and in the first cycle after it, with no input offered, `out_valid` is low and `in_ready` follows `out_ready`.
- R2: Outside the check cycle, `out_valid`, `out_data` and `out_sow` equal `in_valid`, `in_data` and `in_sow` in the same cycle, and `out_eow` is low.
- R3: In the cycle after a byte with `in_eow` high is accepted, `out_valid` and `out_eow` are high and `out_sow` is low.
- R4: The appended byte is A minus the end-around-carry residue of the word's data bytes. The modulo-A sum of the data bytes plus the appended byte is therefore 0 (all-ones counts as 0).
- R5: A byte accepted with `in_sow` high restarts the residue, so bytes taken before it, including an unfinished word, do not affect the next check byte.
- R6: While the check byte is pending, `in_ready` is low and the check byte stays on `out_data` unchanged until `out_ready` is high. After that the block returns to pass-through.
- R7: In pass-through, `in_ready` equals `out_ready`, so a data byte offered while the output is stalled is neither taken nor lost.
- R8: A word whose data bytes are all zero gets the all-ones check byte. A word with a nonzero byte whose data sum is a multiple of A gets the all-zeros check byte.
- R9: A one-byte word (`in_sow` and `in_eow` high together) gets the bitwise complement of that byte as its check byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input byte offered |
| in_ready | output | 1 | Input byte taken when high together with in_valid |
| in_data | input | N | Data byte |
| in_sow | input | 1 | First byte of a word |
| in_eow | input | 1 | Last data byte of a word |
| out_valid | output | 1 | Output byte offered |
| out_ready | input | 1 | Downstream takes the output byte |
| out_data | output | N | Forwarded data byte or check byte |
| out_sow | output | 1 | First byte of an encoded word |
| out_eow | output | 1 | Marks the appended check byte |

## Verification
The zero-sum property assumes that every word on the input begins with a start-of-word byte. It also assumes that the downstream side does not reorder bytes. The stimulus therefore opens every word with the start flag, except for one deliberately abandoned word, and that word is followed by a fresh start. The bench drives inputs only between clock edges and keeps an offered byte stable until it is taken. This matches what the assertions expect of a well-behaved upstream source.

// File: rtl/ir_enc_pkg.sv
`timescale 1ns/1ps
package ir_enc_pkg;

    // Where the encoder is within one encoded word.
    typedef enum logic {
        PH_DATA  = 1'b0,
        PH_CHECK = 1'b1
    } phase_e;

    // One handshake event on the input side.
    typedef struct packed {
        logic take;
        logic first;
        logic last;
    } beat_t;

endpackage

// File: rtl/ir_eac_add.sv
`timescale 1ns/1ps
// One's-complement (end-around-carry) adder, modulo 2^N - 1.
module ir_eac_add #(
    parameter int N = 8
) (
    input  logic [N-1:0] a,
    input  logic [N-1:0] b,
    output logic [N-1:0] s
);
    localparam int WIDE = N + 1;

    logic [WIDE-1:0] raw;

    always_comb begin
        raw = {1'b0, a} + {1'b0, b};
        s   = raw[N-1:0] + {{(N-1){1'b0}}, raw[N]};
    end
endmodule

// File: rtl/ir_residue_acc.sv
`timescale 1ns/1ps
module ir_residue_acc
    import ir_enc_pkg::*;
#(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  beat_t        beat,
    input  logic [N-1:0] din,
    output logic [N-1:0] acc
);
    logic [N-1:0] base;
    logic [N-1:0] nxt;

    // A start-of-word byte adds onto zero instead of the old residue.
    assign base = beat.first ? '0 : acc;

    ir_eac_add #(.N(N)) u_add (
        .a(base),
        .b(din),
        .s(nxt)
    );

    always_ff @(posedge clk) begin
        if (rst)            acc <= '0;
        else if (beat.take) acc <= nxt;
    end

    // R5: a start byte leaves exactly that byte as the residue.
    a_r5_restart: assert property (@(posedge clk) disable iff (rst)
        (beat.take && beat.first) |=> (acc == $past(din)));
endmodule

// File: rtl/ir_phase_ctrl.sv
`timescale 1ns/1ps
module ir_phase_ctrl
    import ir_enc_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  beat_t  beat,
    input  logic   chk_done,
    output phase_e phase
);
    phase_e phase_nxt;

    always_comb begin
        phase_nxt = phase;
        unique case (phase)
            PH_DATA:  if (beat.take && beat.last) phase_nxt = PH_CHECK;
            PH_CHECK: if (chk_done)               phase_nxt = PH_DATA;
            default:                              phase_nxt = PH_DATA;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) phase <= PH_DATA;
        else     phase <= phase_nxt;
    end

    // R6: the check cycle is held until the byte leaves.
    a_r6_hold_check: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_CHECK && !chk_done) |=> (phase == PH_CHECK));

    // R6: nothing is taken from the input while the check byte is pending.
    a_r6_no_take: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_CHECK) |-> !beat.take);
endmodule

// File: rtl/ir_encoder.sv
`timescale 1ns/1ps
module ir_encoder
    import ir_enc_pkg::*;
#(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [N-1:0] in_data,
    input  logic         in_sow,
    input  logic         in_eow,
    output logic         out_valid,
    input  logic         out_ready,
    output logic [N-1:0] out_data,
    output logic         out_sow,
    output logic         out_eow
);
    localparam logic [N-1:0] ALL_ONES = '1;

    phase_e       phase;
    beat_t        beat;
    logic         in_check;
    logic         chk_done;
    logic [N-1:0] residue;

    assign in_check   = (phase == PH_CHECK);
    assign in_ready   = out_ready && !in_check;
    assign beat.take  = in_valid && in_ready;
    assign beat.first = in_sow;
    assign beat.last  = in_eow;
    assign chk_done   = in_check && out_ready;

    // A - r equals ~r, because A is all ones.
    assign out_valid = in_check ? 1'b1 : in_valid;
    assign out_data  = in_check ? (ALL_ONES ^ residue) : in_data;
    assign out_sow   = !in_check && in_sow;
    assign out_eow   = in_check;

    ir_residue_acc #(.N(N)) u_acc (
        .clk (clk),
        .rst (rst),
        .beat(beat),
        .din (in_data),
        .acc (residue)
    );

    ir_phase_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .beat    (beat),
        .chk_done(chk_done),
        .phase   (phase)
    );

    // ---- stream monitor: modular sum of everything leaving the block ----
    function automatic logic [N-1:0] mod_add(input logic [N-1:0] a, input logic [N-1:0] b);
        logic [N:0] r;
        r = {1'b0, a} + {1'b0, b};
        return r[N-1:0] + {{(N-1){1'b0}}, r[N]};
    endfunction

    logic [N-1:0] mon_sum;
    logic [N-1:0] mon_total;
    logic         out_fire;

    assign out_fire  = out_valid && out_ready;
    assign mon_total = mod_add(out_sow ? '0 : mon_sum, out_data);

    always_ff @(posedge clk) begin
        if (rst)           mon_sum <= '0;
        else if (out_fire) mon_sum <= mon_total;
    end

    // R4: the encoded word sums to zero modulo A.
    a_r4_zero_sum: assert property (@(posedge clk) disable iff (rst)
        (out_fire && out_eow) |-> (mon_total == '0 || mon_total == ALL_ONES));

    // R3: the check byte follows the accepted last data byte.
    a_r3_check_follows: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && in_eow) |=> (out_valid && out_eow && !out_sow));

    // R6: a stalled check byte keeps its value.
    a_r6_check_stable: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_eow && !out_ready) |=> (out_eow && $stable(out_data)));

    // R7: a stalled output never takes input.
    a_r7_stall_blocks: assert property (@(posedge clk) disable iff (rst)
        !out_ready |-> !in_ready);
endmodule

// File: tb/ir_encoder_test.sv
`timescale 1ns/1ps
module ir_encoder_test;
    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [N-1:0] in_data = '0;
    logic         in_sow = 1'b0;
    logic         in_eow = 1'b0;
    logic         out_valid;
    logic         out_ready = 1'b1;
    logic [N-1:0] out_data;
    logic         out_sow;
    logic         out_eow;

    int n_vec  = 0;
    int n_miss = 0;
    int msum   = 0;
    bit mzero  = 1'b1;

    always #10 clk = ~clk;   // 50 MHz

    ir_encoder #(.N(N)) uut (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .in_sow(in_sow), .in_eow(in_eow),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_sow(out_sow), .out_eow(out_eow)
    );

    // {sow, eow, data}
    localparam logic [9:0] VEC [12] = '{
        10'h212, 10'h034, 10'h056, 10'h178,
        10'h2FF, 10'h0FF, 10'h101,
        10'h3A5,
        10'h280, 10'h080, 10'h080, 10'h180
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_miss++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int model_check();
        int r;
        r = msum % 255;
        if (mzero)   return 255;
        if (r == 0)  return 0;
        return 255 - r;
    endfunction

    task automatic put_byte(input logic [7:0] d, input logic s, input logic e);
        @(negedge clk);
        in_valid = 1'b1; in_data = d; in_sow = s; in_eow = e; out_ready = 1'b1;
        #1;
        check(out_valid && out_data == d && out_sow == s && !out_eow, "R2 passthrough",
              {out_valid, out_sow, out_eow, out_data}, {1'b1, s, 1'b0, d});
        if (s) begin msum = 0; mzero = 1'b1; end
        msum += d;
        if (d != 0) mzero = 1'b0;
        @(posedge clk);
        if (e) begin
            @(negedge clk);
            in_valid = 1'b0; in_sow = 1'b0; in_eow = 1'b0;
            #1;
            check(out_valid && out_eow && !out_sow && !in_ready, "R3 check slot",
                  {out_valid, out_eow, out_sow, in_ready}, 4'b1100);
            check(out_data == model_check(), "R4 check value", out_data, model_check());
            @(posedge clk);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_miss++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        #1;
        check(!out_valid && in_ready, "R1 in reset", {out_valid, in_ready}, 2'b01);
        rst = 1'b0;
        @(negedge clk);
        out_ready = 1'b0;
        #1;
        check(!out_valid && !in_ready && !out_eow, "R1 after reset",
              {out_valid, in_ready, out_eow}, 3'b000);
        out_ready = 1'b1;

        // Table walk (R2, R3, R4, R9 on the single-byte word)
        for (int i = 0; i < 12; i++)
            put_byte(VEC[i][7:0], VEC[i][9], VEC[i][8]);

        // R9: single byte, complement
        put_byte(8'h3C, 1'b1, 1'b1);
        check(msum == 8'h3C && model_check() == 8'hC3, "R9 model", model_check(), 8'hC3);

        // R8: all-zero word gives all ones; sum of 255 gives zero
        put_byte(8'h00, 1'b1, 1'b0);
        put_byte(8'h00, 1'b0, 1'b1);
        put_byte(8'h0F, 1'b1, 1'b0);
        put_byte(8'hF0, 1'b0, 1'b1);

        // R5: abandoned word, then restart
        put_byte(8'h55, 1'b1, 1'b0);
        put_byte(8'h22, 1'b0, 1'b0);
        put_byte(8'h10, 1'b1, 1'b1);

        // R7: stalled data byte is not taken
        @(negedge clk);
        in_valid = 1'b1; in_data = 8'h40; in_sow = 1'b1; in_eow = 1'b0; out_ready = 1'b0;
        #1;
        check(!in_ready && out_valid && out_data == 8'h40, "R7 stall data",
              {in_ready, out_data}, {1'b0, 8'h40});
        @(posedge clk);
        @(negedge clk);
        out_ready = 1'b1;
        #1;
        check(in_ready && out_data == 8'h40 && out_sow, "R7 resume",
              {in_ready, out_sow, out_data}, {2'b11, 8'h40});
        @(posedge clk);
        @(negedge clk);
        in_data = 8'h30; in_sow = 1'b0; in_eow = 1'b1;
        @(posedge clk);
        // R6: check byte pending under backpressure, new word refused
        @(negedge clk);
        out_ready = 1'b0; in_valid = 1'b1; in_data = 8'h77; in_sow = 1'b1; in_eow = 1'b1;
        #1;
        check(out_eow && !in_ready && out_data == 8'h8F, "R6 pending",
              {out_eow, in_ready, out_data}, {2'b10, 8'h8F});
        @(posedge clk);
        @(negedge clk);
        #1;
        check(out_valid && out_eow && out_data == 8'h8F, "R6 held",
              {out_valid, out_eow, out_data}, {2'b11, 8'h8F});
        out_ready = 1'b1; in_valid = 1'b0;
        @(posedge clk);
        @(negedge clk);
        #1;
        check(!out_valid && !out_eow && in_ready, "R6 back to data",
              {out_valid, out_eow, in_ready}, 3'b001);

        // The refused byte was not absorbed: a clean single-byte word encodes alone.
        put_byte(8'h01, 1'b1, 1'b1);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
        $finish;
    end
endmodule